// File: doc/BRIEF.md
# FSK Carrier Qualifier and Interrupt Merger

This block turns a raw carrier-energy flag from an FSK receive front end into a clean, active-low carrier-detect line. The line asserts only after the energy has been present without a break for an acquire window. It releases only after the energy has been absent for a longer release window. The same block merges three unrelated event sources into one active-low interrupt: a ring-detect flag (active low), a byte-ready strobe (active low) and a qualified dual tone flag (active high).

The block also sequences power-down. While power-down is asserted, both outputs sit high and the oscillator-ready indication is low. When power-down is released, a warm-up timer runs. No carrier or event is passed on until the timer expires, and this timer also runs after reset.

Every input is asynchronous and passes through a two-stage synchronizer. All windows are set in milliseconds and scaled by a cycles-per-millisecond parameter. An output therefore trails its inputs by the synchronizer latency plus at most one state update, which is three clock cycles in total.

Top module: `carrier_irq_ctrl`

## Requirements
- R1: `carrierDetN` falls only after `carrierRaw` has been high without a break for ACQ_MS milliseconds, and no later than 6 clock cycles after that point.
- R2: Once carrier is detected, `carrierDetN` rises between REL_MS milliseconds and REL_MS milliseconds plus 6 cycles after `carrierRaw` falls for the last time.
- R3: When `oscReady` is high and power-down is low, `intN` is low exactly when `ringDetN` is low, `byteReadyN` is low or `toneHit` is high. Each input change shows on `intN` within 3 cycles.
- R4: When `powerDown` is high, `carrierDetN` and `intN` are high within 3 cycles and `oscReady` is low within 4 cycles.
- R5: `oscReady` rises between OSC_MS milliseconds and OSC_MS milliseconds plus 6 cycles after reset is released or `powerDown` falls.
- R6: When `fskEnable` is low, `carrierDetN` is high within 3 cycles. `intN` is not affected by `fskEnable`.
- R7: A dropout of `carrierRaw` of 3 or more cycles during acquisition restarts the acquire window from the next rising edge.
- R8: After carrier is detected, any return of `carrierRaw` within the release window restarts the release window, and `carrierDetN` stays low.
- R9: While `oscReady` is low, events and carrier energy are ignored, and `intN` and `carrierDetN` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| carrierRaw | input | 1 | Raw carrier-energy flag, high when energy is present |
| ringDetN | input | 1 | Ring detect, active low |
| byteReadyN | input | 1 | Byte-ready strobe, active low |
| toneHit | input | 1 | Qualified dual tone flag, active high |
| fskEnable | input | 1 | High enables carrier detection |
| powerDown | input | 1 | High requests power-down |
| carrierDetN | output | 1 | Qualified carrier detect, active low |
| intN | output | 1 | Merged interrupt, active low |
| oscReady | output | 1 | High once the warm-up after power-up has expired |

## Verification
The assertions check the following on every cycle:
- both outputs stay quiet while not ready or powered down;
- `carrierDetN` is released when enable is low;
- any event held for three cycles produces an interrupt;
- a carrier assertion is preceded by an unbroken energy run of the acquire length;
- the ready flag never rises before a full warm-up;
- sustained energy holds the carrier.

Only the bench scenarios can show the upper edges of the windows, that is, that acquire, release and warm-up each end within their tolerance. They also cover the two restart cases: a short dropout during acquisition and a brief return of energy during release. Finally, the bench shows that events arriving during warm-up are dropped instead of stored.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

  typedef enum logic [2:0] {
    ST_DOWN,
    ST_WARM,
    ST_IDLE,
    ST_ACQ,
    ST_ON
  } cdiState_e;

  // control -> datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic ready;
    logic carrierOn;
  } cdiStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic energy;
    logic enable;
    logic pwrDown;
    logic warmDone;
    logic acqDone;
    logic relDone;
  } cdiStatus_t;

endpackage

// File: rtl/cdi_datapath.sv
module cdi_datapath
  import cdi_pkg::*;
#(
  parameter int OSC_CYC = 100,
  parameter int ACQ_CYC = 120,
  parameter int REL_CYC = 160
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierRaw,
  input  logic       ringDetN,
  input  logic       byteReadyN,
  input  logic       toneHit,
  input  logic       fskEnable,
  input  logic       powerDown,
  input  cdiStrobe_t strobe,
  output cdiStatus_t status,
  output logic       carrierDetN,
  output logic       intN
);

  localparam int MAX_AB  = (OSC_CYC > ACQ_CYC) ? OSC_CYC : ACQ_CYC;
  localparam int MAX_CYC = (MAX_AB > REL_CYC) ? MAX_AB : REL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int N_IN    = 6;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] OSC_LAST = CNT_W'(OSC_CYC - 1);
  localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(REL_CYC - 1);

  // bit map: 5 pd, 4 enable, 3 tone, 2 byte, 1 ring, 0 energy
  // reset values keep every source in its inactive level, with power-down asserted
  localparam logic [N_IN-1:0] SYNC_RST = 6'b100110;

  logic [N_IN-1:0] rawIn, meta, stab;
  logic [CNT_W-1:0] cnt;
  logic eventAny;

  assign rawIn = {powerDown, fskEnable, toneHit, byteReadyN, ringDetN, carrierRaw};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= SYNC_RST;
      stab <= SYNC_RST;
    end else begin
      meta <= rawIn;
      stab <= meta;
    end
  end

  // shared window timer: warm-up, acquire and release never overlap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               cnt <= '0;
    else if (strobe.cntClr)                  cnt <= '0;
    else if (strobe.cntInc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign status.energy   = stab[0];
  assign status.enable   = stab[4];
  assign status.pwrDown  = stab[5];
  assign status.warmDone = (cnt == OSC_LAST);
  assign status.acqDone  = (cnt == ACQ_LAST);
  assign status.relDone  = (cnt == REL_LAST);

  assign eventAny    = ~stab[1] | ~stab[2] | stab[3];
  assign intN        = ~(strobe.ready & ~stab[5] & eventAny);
  assign carrierDetN = ~(strobe.carrierOn & stab[4] & ~stab[5]);

endmodule

// File: rtl/cdi_control.sv
module cdi_control
  import cdi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cdiStatus_t status,
  output cdiStrobe_t strobe,
  output logic       oscReady
);

  cdiState_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_DOWN;
    else       state <= nxt;
  end

  always_comb begin
    nxt    = state;
    strobe = '0;
    unique case (state)
      ST_DOWN: begin
        strobe.cntClr = 1'b1;
        if (!status.pwrDown) nxt = ST_WARM;
      end
      ST_WARM: begin
        strobe.cntInc = 1'b1;
        if (status.warmDone) begin
          nxt           = ST_IDLE;
          strobe.cntClr = 1'b1;
        end
      end
      ST_IDLE: begin
        strobe.ready  = 1'b1;
        strobe.cntClr = 1'b1;
        if (status.enable && status.energy) nxt = ST_ACQ;
      end
      ST_ACQ: begin
        strobe.ready = 1'b1;
        if (!status.enable || !status.energy) begin
          nxt           = ST_IDLE;
          strobe.cntClr = 1'b1;
        end else if (status.acqDone) begin
          nxt           = ST_ON;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_ON: begin
        strobe.ready     = 1'b1;
        strobe.carrierOn = 1'b1;
        if (!status.enable) begin
          nxt           = ST_IDLE;
          strobe.cntClr = 1'b1;
        end else if (status.energy) begin
          strobe.cntClr = 1'b1;
        end else if (status.relDone) begin
          nxt           = ST_IDLE;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: nxt = ST_DOWN;
    endcase
    if (status.pwrDown) begin
      nxt              = ST_DOWN;
      strobe.cntClr    = 1'b1;
      strobe.ready     = 1'b0;
      strobe.carrierOn = 1'b0;
    end
  end

  assign oscReady = (state == ST_IDLE) || (state == ST_ACQ) || (state == ST_ON);

endmodule

// File: rtl/carrier_irq_ctrl.sv
module carrier_irq_ctrl
  import cdi_pkg::*;
#(
  parameter int CYCLES_PER_MS = 3580,
  parameter int OSC_MS        = 5,
  parameter int ACQ_MS        = 6,
  parameter int REL_MS        = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic carrierRaw,
  input  logic ringDetN,
  input  logic byteReadyN,
  input  logic toneHit,
  input  logic fskEnable,
  input  logic powerDown,
  output logic carrierDetN,
  output logic intN,
  output logic oscReady
);

  localparam int OSC_CYC = CYCLES_PER_MS * OSC_MS;
  localparam int ACQ_CYC = CYCLES_PER_MS * ACQ_MS;
  localparam int REL_CYC = CYCLES_PER_MS * REL_MS;

  cdiStrobe_t strobe;
  cdiStatus_t status;

  cdi_datapath #(
    .OSC_CYC(OSC_CYC),
    .ACQ_CYC(ACQ_CYC),
    .REL_CYC(REL_CYC)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .carrierRaw (carrierRaw),
    .ringDetN   (ringDetN),
    .byteReadyN (byteReadyN),
    .toneHit    (toneHit),
    .fskEnable  (fskEnable),
    .powerDown  (powerDown),
    .strobe     (strobe),
    .status     (status),
    .carrierDetN(carrierDetN),
    .intN       (intN)
  );

  cdi_control i_control (
    .clk     (clk),
    .rstN    (rstN),
    .status  (status),
    .strobe  (strobe),
    .oscReady(oscReady)
  );

endmodule

// File: rtl/cdi_checker.sv
module cdi_checker #(
  parameter int CYCLES_PER_MS = 3580,
  parameter int OSC_MS        = 5,
  parameter int ACQ_MS        = 6,
  parameter int REL_MS        = 8
) (
  input logic clk,
  input logic rstN,
  input logic carrierRaw,
  input logic ringDetN,
  input logic byteReadyN,
  input logic toneHit,
  input logic fskEnable,
  input logic powerDown,
  input logic carrierDetN,
  input logic intN,
  input logic oscReady
);

  localparam int OSC_CYC = CYCLES_PER_MS * OSC_MS;
  localparam int ACQ_CYC = CYCLES_PER_MS * ACQ_MS;
  localparam int REL_CYC = CYCLES_PER_MS * REL_MS;
  localparam int TOP     = OSC_CYC + ACQ_CYC + REL_CYC + 8;
  localparam int CW      = $clog2(TOP + 1);

  logic [CW-1:0] carDlyRun, rawRun, pdLowRun, pdHighRun, enLowRun, enHighRun;
  logic [CW-1:0] ringLowRun, byteLowRun, toneHighRun;
  logic carD1, carD2;

  function automatic logic [CW-1:0] bump(input logic cond, input logic [CW-1:0] v);
    if (!cond) return '0;
    return (v == CW'(TOP)) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carD1 <= 1'b0; carD2 <= 1'b0;
      carDlyRun <= '0; rawRun <= '0; pdLowRun <= '0; pdHighRun <= '0;
      enLowRun <= '0; enHighRun <= '0; ringLowRun <= '0; byteLowRun <= '0; toneHighRun <= '0;
    end else begin
      carD1       <= carrierRaw;
      carD2       <= carD1;
      carDlyRun   <= bump(carD2, carDlyRun);
      rawRun      <= bump(carrierRaw, rawRun);
      pdLowRun    <= bump(!powerDown, pdLowRun);
      pdHighRun   <= bump(powerDown, pdHighRun);
      enLowRun    <= bump(!fskEnable, enLowRun);
      enHighRun   <= bump(fskEnable, enHighRun);
      ringLowRun  <= bump(!ringDetN, ringLowRun);
      byteLowRun  <= bump(!byteReadyN, byteLowRun);
      toneHighRun <= bump(toneHit, toneHighRun);
    end
  end

  AST_ACQ_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(carrierDetN) |-> $past(carDlyRun) >= CW'(ACQ_CYC)); // R1

  AST_HOLD_WHILE_ENERGY: assert property (@(posedge clk) disable iff (!rstN)
    (!carrierDetN && rawRun >= 3 && enHighRun >= 3 && pdLowRun >= 3) |=> !carrierDetN); // R8

  AST_EVENT_RAISES_INT: assert property (@(posedge clk) disable iff (!rstN)
    (oscReady && pdLowRun >= 3 && (ringLowRun >= 3 || byteLowRun >= 3 || toneHighRun >= 3)) |-> !intN); // R3

  AST_POWERDOWN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (pdHighRun >= 4) |-> (carrierDetN && intN && !oscReady)); // R4

  AST_WARMUP_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscReady) |-> pdLowRun >= CW'(OSC_CYC)); // R5

  AST_ENABLE_GATES_CARRIER: assert property (@(posedge clk) disable iff (!rstN)
    (enLowRun >= 3) |-> carrierDetN); // R6

  AST_NOT_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !oscReady |-> (intN && carrierDetN)); // R9

endmodule

bind carrier_irq_ctrl cdi_checker #(
  .CYCLES_PER_MS(CYCLES_PER_MS),
  .OSC_MS       (OSC_MS),
  .ACQ_MS       (ACQ_MS),
  .REL_MS       (REL_MS)
) i_cdi_checker (.*);

// File: tb/test_carrier_irq_ctrl.sv
module test_carrier_irq_ctrl;

  localparam int CPM = 20;
  localparam int OSC = CPM * 5;
  localparam int ACQ = CPM * 6;
  localparam int REL = CPM * 8;
  localparam int SLACK = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic carrierRaw = 1'b0, ringDetN = 1'b1, byteReadyN = 1'b1, toneHit = 1'b0;
  logic fskEnable = 1'b1, powerDown = 1'b0;
  logic carrierDetN, intN, oscReady;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  carrier_irq_ctrl #(.CYCLES_PER_MS(CPM)) i_carrier_irq_ctrl (
    .clk(clk), .rstN(rstN), .carrierRaw(carrierRaw), .ringDetN(ringDetN),
    .byteReadyN(byteReadyN), .toneHit(toneHit), .fskEnable(fskEnable),
    .powerDown(powerDown), .carrierDetN(carrierDetN), .intN(intN), .oscReady(oscReady)
  );

  function automatic logic expInt(input logic r, input logic b, input logic t);
    return !(!r || !b || t);
  endfunction

  task automatic checkVal(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // which: 0 = carrierDetN, 1 = oscReady
  task automatic waitLevel(input int which, input logic lvl, output int n);
    n = 0;
    while (((which == 0) ? carrierDetN : oscReady) !== lvl && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    idle(3);
    // reset state
    checkVal("R4 reset carrierDetN", int'(carrierDetN), 1);
    checkVal("R4 reset intN", int'(intN), 1);
    checkVal("R5 reset oscReady", int'(oscReady), 0);

    // R5 warm-up after reset, R9 events during warm-up ignored
    rstN = 1'b1;
    ringDetN = 1'b0;
    carrierRaw = 1'b1;
    waitLevel(1, 1'b1, n);
    checkRange("R5 warm-up after reset", n, OSC, OSC + SLACK);
    ringDetN = 1'b1;
    carrierRaw = 1'b0;
    idle(30);
    checkVal("R9 warm-up event dropped intN", int'(intN), 1);
    checkVal("R9 warm-up energy dropped carrierDetN", int'(carrierDetN), 1);

    // R3 directed then random
    ringDetN = 1'b0; idle(4);
    checkVal("R3 ring low", int'(intN), 0);
    ringDetN = 1'b1; idle(4);
    checkVal("R3 all idle", int'(intN), 1);
    for (int i = 0; i < 40; i++) begin
      logic r, b, t;
      r = 1'($urandom); b = 1'($urandom); t = 1'($urandom);
      ringDetN = r; byteReadyN = b; toneHit = t;
      idle(4);
      checkVal("R3 random merge", int'(intN), int'(expInt(r, b, t)));
    end
    ringDetN = 1'b1; byteReadyN = 1'b1; toneHit = 1'b0;
    idle(4);

    // R1 acquire
    carrierRaw = 1'b1;
    waitLevel(0, 1'b0, n);
    checkRange("R1 acquire time", n, ACQ, ACQ + SLACK);

    // R8 short gap keeps carrier, release restarts
    carrierRaw = 1'b0; idle(REL - 40);
    checkVal("R8 gap shorter than release", int'(carrierDetN), 0);
    carrierRaw = 1'b1; idle(5);
    carrierRaw = 1'b0; idle(REL - 20);
    checkVal("R8 release restarted", int'(carrierDetN), 0);
    // R2 release completes
    carrierRaw = 1'b1; idle(5);
    carrierRaw = 1'b0;
    waitLevel(0, 1'b1, n);
    checkRange("R2 release time", n, REL, REL + SLACK);

    // R7 dropout restarts acquire
    carrierRaw = 1'b1; idle(ACQ - 20);
    carrierRaw = 1'b0; idle(3);
    checkVal("R7 no carrier before full run", int'(carrierDetN), 1);
    carrierRaw = 1'b1;
    waitLevel(0, 1'b0, n);
    checkRange("R7 acquire restarted", n, ACQ, ACQ + SLACK);

    // R6 enable low drops carrier, interrupt unaffected
    fskEnable = 1'b0; idle(4);
    checkVal("R6 enable low carrierDetN", int'(carrierDetN), 1);
    toneHit = 1'b1; idle(4);
    checkVal("R6 intN with enable low", int'(intN), 0);
    toneHit = 1'b0;
    idle(ACQ + 20);
    checkVal("R6 no acquire while disabled", int'(carrierDetN), 1);
    fskEnable = 1'b1;
    waitLevel(0, 1'b0, n);
    checkRange("R6 reacquire after enable", n, ACQ, ACQ + SLACK);

    // R4 power-down
    byteReadyN = 1'b0;
    powerDown = 1'b1; idle(4);
    checkVal("R4 pd carrierDetN", int'(carrierDetN), 1);
    checkVal("R4 pd intN", int'(intN), 1);
    checkVal("R4 pd oscReady", int'(oscReady), 0);
    powerDown = 1'b0;
    waitLevel(1, 1'b1, n);
    checkRange("R5 warm-up after power-down", n, OSC, OSC + SLACK);
    idle(4);
    checkVal("R3 event after warm-up", int'(intN), 0);
    byteReadyN = 1'b1;
    idle(4);
    checkVal("R3 event cleared", int'(intN), 1);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog covering R1 to R9 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule